// File: doc/BRIEF.md
# SRAM Replica-Timed Access Sequencer

This block sequences the read port and the write port of a two-port SRAM macro with 1024 rows of 128 bits. The rows are grouped into 64 local blocks of 16 rows. Each port runs its own four-phase cycle. In the idle phase the bit lines are precharged. In the open phase precharge is released. In the pulse phase the selected word line and a dummy word line are raised. In the close phase both word lines are dropped, and precharge comes back one clock later.

The end of the word-line pulse is not set by a fixed number of clocks. It is set by a done flag from a dummy path that fires on every access of that port. The read side waits for the read replica chain. The write side waits for a write monitor cell, and the block also pulses the reset of that monitor when the write closes. A watchdog limits how long a pulse can last if the done flag never arrives.

The row address is split into a block field and a local-row field. The block drives one of 64 block selects and one of 16 row selects, and a row's word line is the AND of the two.

Top module: `sram_replica_timer`

## Requirements
- R1: After reset, both precharge enables and both ready outputs are 1. All word-line selects, dummy word lines, write drivers, the dummy-bit-line pull-low, the monitor reset and both error flags are 0.
- R2: A read request sampled while `rd_ready` is 1 drops `rd_pre_en` after that edge, with the word lines still off. After the next edge the selected read word line and `rd_dummy_wl` rise together, and `rd_pre_en` stays 0 for as long as they are high.
- R3: While a port's word line is active, exactly one block select is high, at bit index addr[9:4], and exactly one row select is high, at bit index addr[3:0]. While it is inactive, all selects are 0.
- R4: When `rd_done` is 1 at an edge of the pulse phase, the word lines are low after that edge. `rd_pre_en` stays 0 for one further cycle, and then `rd_pre_en` and `rd_ready` return to 1.
- R5: On a write, `wr_pre_en` is 0 and `wr_drv_en` and `wr_dbl_low` are 1 from the cycle after acceptance through the pulse. The write word line and `wr_dummy_wl` rise one cycle after acceptance plus one, exactly as on the read side.
- R6: When `wr_done` is 1 at an edge of the pulse phase, the write word lines are low after it. `wr_mon_rst` is 1 for exactly that one close cycle, and then `wr_pre_en` returns.
- R7: If the done flag never arrives, the word lines stay high for exactly max(`tmo_limit`,1) cycles and then close as if done, and the port's error flag is set. The error flag stays set until the next request of that port is accepted. Done arriving on the last allowed cycle does not set the flag.
- R8: Ready is 0 from acceptance until precharge is restored. A request presented while ready is 0 starts no cycle.
- R9: The read and write ports run concurrently without affecting each other's sequence.
- R10: A done flag seen in the open phase is ignored and does not shorten the pulse.
- R11: The address is captured at acceptance. Changes to the address input during a cycle do not move the selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_limit | input | 8 | Watchdog limit in cycles (0 acts as 1) |
| rd_req | input | 1 | Read request |
| rd_addr | input | 10 | Read row address |
| rd_done | input | 1 | Read replica done flag |
| wr_req | input | 1 | Write request |
| wr_addr | input | 10 | Write row address |
| wr_done | input | 1 | Write monitor done flag |
| rd_ready | output | 1 | Read port can accept a request |
| rd_pre_en | output | 1 | Local/global read bit-line precharge enable |
| rd_dummy_wl | output | 1 | Dummy read word line |
| rd_blk_sel | output | 64 | One-hot read block select |
| rd_row_sel | output | 16 | One-hot read local-row select |
| rd_err | output | 1 | Read watchdog expired |
| wr_ready | output | 1 | Write port can accept a request |
| wr_pre_en | output | 1 | Write bit-line precharge enable |
| wr_drv_en | output | 1 | Local and global write driver enable |
| wr_dbl_low | output | 1 | Pull dummy write bit line to 0 |
| wr_dummy_wl | output | 1 | Dummy write word line |
| wr_blk_sel | output | 64 | One-hot write block select |
| wr_row_sel | output | 16 | One-hot write local-row select |
| wr_mon_rst | output | 1 | Write monitor reset to idle |
| wr_err | output | 1 | Write watchdog expired |

## Verification
Every row address is swept on both ports. This catches any swap of the block and local-row fields, which would light the wrong select. A done flag is pulsed during the open phase, and the address and request inputs are changed during a busy cycle. A design that acted on those would cut the pulse short, move the selects, or start an extra cycle that the following idle check would see. The watchdog is tested at limits 0 to 5, both with no done and with done on exactly the last allowed cycle. An off-by-one in the counter shows as a wrong pulse length or a spurious error. Concurrent read and write cycles with different pulse lengths expose any state the two ports wrongly share.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OPEN  = 2'd1,
    PH_PULSE = 2'd2,
    PH_CLOSE = 2'd3
  } phase_e;
endpackage

// File: rtl/srt_port_seq.sv
module srt_port_seq
  import srt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              done,
  input  logic [TMO_W-1:0]  limit,
  output phase_e            phase,
  output logic [ADDR_W-1:0] addr_q,
  output logic              err
);
  phase_e            st_q, st_d;
  logic [TMO_W-1:0]  cnt_q, cnt_d;
  logic [TMO_W:0]    cnt_nxt;
  logic              err_q, err_d;
  logic              addr_ld;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    addr_ld = 1'b0;
    case (st_q)
      PH_IDLE: if (req) begin
        st_d    = PH_OPEN;
        addr_ld = 1'b1;
        err_d   = 1'b0;
      end
      PH_OPEN: begin
        st_d  = PH_PULSE;
        cnt_d = '0;
      end
      PH_PULSE: begin
        cnt_d = cnt_nxt[TMO_W-1:0];
        if (done) begin
          st_d = PH_CLOSE;
        end else if (cnt_nxt >= {1'b0, limit}) begin
          st_d  = PH_CLOSE;
          err_d = 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
      if (addr_ld) addr_q <= addr;
    end
  end

  assign phase = st_q;
  assign err   = err_q;
endmodule

// File: rtl/srt_wl_decoder.sv
module srt_wl_decoder #(
  parameter int BLK_W  = 6,
  parameter int LROW_W = 4
) (
  input  logic                     en,
  input  logic [BLK_W+LROW_W-1:0]  addr,
  output logic [(1<<BLK_W)-1:0]    blk_sel,
  output logic [(1<<LROW_W)-1:0]   row_sel
);
  localparam int NBLK = 1 << BLK_W;
  localparam int NROW = 1 << LROW_W;

  logic [BLK_W-1:0]  blk_f;
  logic [LROW_W-1:0] row_f;
  assign blk_f = addr[BLK_W+LROW_W-1:LROW_W];
  assign row_f = addr[LROW_W-1:0];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk_sel[b] = en && (blk_f == BLK_W'(b));
  end
  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign row_sel[r] = en && (row_f == LROW_W'(r));
  end
endmodule

// File: rtl/sram_replica_timer.sv
module sram_replica_timer
  import srt_pkg::*;
#(
  parameter int BLK_W  = 6,
  parameter int LROW_W = 4,
  parameter int TMO_W  = 8,
  localparam int ADDR_W = BLK_W + LROW_W,
  localparam int NBLK   = 1 << BLK_W,
  localparam int NROW   = 1 << LROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_done,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_done,
  output logic              rd_ready,
  output logic              rd_pre_en,
  output logic              rd_dummy_wl,
  output logic [NBLK-1:0]   rd_blk_sel,
  output logic [NROW-1:0]   rd_row_sel,
  output logic              rd_err,
  output logic              wr_ready,
  output logic              wr_pre_en,
  output logic              wr_drv_en,
  output logic              wr_dbl_low,
  output logic              wr_dummy_wl,
  output logic [NBLK-1:0]   wr_blk_sel,
  output logic [NROW-1:0]   wr_row_sel,
  output logic              wr_mon_rst,
  output logic              wr_err
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  phase_e            rd_ph, wr_ph;
  logic [ADDR_W-1:0] rd_aq, wr_aq;

  srt_port_seq #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_rd_seq (
    .clk(clk), .rst_n(rst_int_n), .req(rd_req), .addr(rd_addr),
    .done(rd_done), .limit(tmo_limit), .phase(rd_ph), .addr_q(rd_aq),
    .err(rd_err)
  );

  srt_port_seq #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_wr_seq (
    .clk(clk), .rst_n(rst_int_n), .req(wr_req), .addr(wr_addr),
    .done(wr_done), .limit(tmo_limit), .phase(wr_ph), .addr_q(wr_aq),
    .err(wr_err)
  );

  assign rd_ready    = (rd_ph == PH_IDLE);
  assign rd_pre_en   = (rd_ph == PH_IDLE);
  assign rd_dummy_wl = (rd_ph == PH_PULSE);

  assign wr_ready    = (wr_ph == PH_IDLE);
  assign wr_pre_en   = (wr_ph == PH_IDLE);
  assign wr_dummy_wl = (wr_ph == PH_PULSE);
  assign wr_drv_en   = (wr_ph == PH_OPEN) || (wr_ph == PH_PULSE);
  assign wr_dbl_low  = (wr_ph == PH_OPEN) || (wr_ph == PH_PULSE);
  assign wr_mon_rst  = (wr_ph == PH_CLOSE);

  srt_wl_decoder #(.BLK_W(BLK_W), .LROW_W(LROW_W)) u_rd_dec (
    .en(rd_ph == PH_PULSE), .addr(rd_aq),
    .blk_sel(rd_blk_sel), .row_sel(rd_row_sel)
  );

  srt_wl_decoder #(.BLK_W(BLK_W), .LROW_W(LROW_W)) u_wr_dec (
    .en(wr_ph == PH_PULSE), .addr(wr_aq),
    .blk_sel(wr_blk_sel), .row_sel(wr_row_sel)
  );
endmodule

// File: rtl/srt_timing_chk.sv
module srt_timing_chk #(
  parameter int NBLK  = 64,
  parameter int NROW  = 16,
  parameter int TMO_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TMO_W-1:0] tmo_limit,
  input logic             rd_done,
  input logic             wr_done,
  input logic             rd_pre_en,
  input logic             rd_dummy_wl,
  input logic [NBLK-1:0]  rd_blk_sel,
  input logic [NROW-1:0]  rd_row_sel,
  input logic             wr_pre_en,
  input logic             wr_drv_en,
  input logic             wr_dbl_low,
  input logic             wr_dummy_wl,
  input logic [NBLK-1:0]  wr_blk_sel,
  input logic [NROW-1:0]  wr_row_sel,
  input logic             wr_mon_rst
);
  logic [TMO_W:0] rd_run, wr_run, eff_lim;
  assign eff_lim = (tmo_limit == '0) ? (TMO_W+1)'(1) : {1'b0, tmo_limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= rd_dummy_wl ? rd_run + 1'b1 : '0;
      wr_run <= wr_dummy_wl ? wr_run + 1'b1 : '0;
    end
  end

  p_rd_wl_no_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dummy_wl || (|rd_blk_sel)) |-> !rd_pre_en);
  p_rd_open_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_dummy_wl) |-> $past(!rd_pre_en));
  p_rd_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_blk_sel) && $onehot0(rd_row_sel) && ((|rd_row_sel) == rd_dummy_wl));
  p_wr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_blk_sel) && $onehot0(wr_row_sel) && ((|wr_blk_sel) == wr_dummy_wl));
  p_rd_done_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dummy_wl && rd_done) |=> !rd_dummy_wl);
  p_rd_close_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_dummy_wl) |-> !rd_pre_en);
  p_wr_wl_no_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dummy_wl |-> (!wr_pre_en && wr_drv_en && wr_dbl_low));
  p_wr_done_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dummy_wl && wr_done) |=> (!wr_dummy_wl && wr_mon_rst));
  p_wr_mon_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mon_rst |=> (!wr_mon_rst && wr_pre_en));
  p_rd_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dummy_wl |-> (rd_run < eff_lim));
  p_wr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dummy_wl |-> (wr_run < eff_lim));
  p_rd_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dummy_wl && $past(rd_dummy_wl)) |-> ($stable(rd_blk_sel) && $stable(rd_row_sel)));
endmodule

bind sram_replica_timer srt_timing_chk #(.NBLK(NBLK), .NROW(NROW), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit), .rd_done(rd_done),
  .wr_done(wr_done), .rd_pre_en(rd_pre_en), .rd_dummy_wl(rd_dummy_wl),
  .rd_blk_sel(rd_blk_sel), .rd_row_sel(rd_row_sel), .wr_pre_en(wr_pre_en),
  .wr_drv_en(wr_drv_en), .wr_dbl_low(wr_dbl_low), .wr_dummy_wl(wr_dummy_wl),
  .wr_blk_sel(wr_blk_sel), .wr_row_sel(wr_row_sel), .wr_mon_rst(wr_mon_rst)
);

// File: tb/tb_sram_replica_timer.sv
module tb_sram_replica_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tmo_limit = 8'd8;
  logic        rd_req = 1'b0, wr_req = 1'b0, rd_done = 1'b0, wr_done = 1'b0;
  logic [9:0]  rd_addr = '0, wr_addr = '0;
  logic        rd_ready, rd_pre_en, rd_dummy_wl, rd_err;
  logic        wr_ready, wr_pre_en, wr_drv_en, wr_dbl_low, wr_dummy_wl, wr_mon_rst, wr_err;
  logic [63:0] rd_blk_sel, wr_blk_sel;
  logic [15:0] rd_row_sel, wr_row_sel;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sram_replica_timer dut (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_done(wr_done),
    .rd_ready(rd_ready), .rd_pre_en(rd_pre_en), .rd_dummy_wl(rd_dummy_wl),
    .rd_blk_sel(rd_blk_sel), .rd_row_sel(rd_row_sel), .rd_err(rd_err),
    .wr_ready(wr_ready), .wr_pre_en(wr_pre_en), .wr_drv_en(wr_drv_en),
    .wr_dbl_low(wr_dbl_low), .wr_dummy_wl(wr_dummy_wl),
    .wr_blk_sel(wr_blk_sel), .wr_row_sel(wr_row_sel),
    .wr_mon_rst(wr_mon_rst), .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic drive(input bit wr, input bit req, input logic [9:0] a, input bit dn);
    if (wr) begin wr_req = req; wr_addr = a; wr_done = dn; end
    else    begin rd_req = req; rd_addr = a; rd_done = dn; end
  endtask

  task automatic snap(input bit wr, output logic pre, output logic rdy, output logic dwl,
                      output logic er, output logic [63:0] blk, output logic [15:0] row);
    if (wr) begin pre = wr_pre_en; rdy = wr_ready; dwl = wr_dummy_wl; er = wr_err; blk = wr_blk_sel; row = wr_row_sel; end
    else    begin pre = rd_pre_en; rdy = rd_ready; dwl = rd_dummy_wl; er = rd_err; blk = rd_blk_sel; row = rd_row_sel; end
  endtask

  // dly = pulse cycle on which done is given; 0 = never
  task automatic run_cyc(input bit wr, input logic [9:0] a, input int dly);
    int effl, n;
    bit to;
    logic pre, rdy, dwl, er;
    logic [63:0] blk;
    logic [15:0] row;
    effl = (tmo_limit == 0) ? 1 : int'(tmo_limit);
    to   = (dly == 0) || (dly > effl);
    n    = to ? effl : dly;
    @(negedge clk);
    drive(wr, 1'b1, a, 1'b0);
    @(negedge clk);
    snap(wr, pre, rdy, dwl, er, blk, row);
    eq("R2 open: precharge off", pre, 0);
    eq("R8 open: ready low", rdy, 0);
    eq("R2 open: dummy wl off", dwl, 0);
    eq("R3 open: no select", blk, 0);
    eq("R7 error cleared on accept", er, 0);
    if (wr) begin
      eq("R5 drivers on in open", wr_drv_en, 1);
      eq("R5 dummy bl low in open", wr_dbl_low, 1);
    end
    // busy-time disturbances: R8 new request, R10 early done, R11 address change
    drive(wr, 1'b1, a ^ 10'h3FF, 1'b1);
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (j == 1) drive(wr, 1'b0, a ^ 10'h155, 1'b0);
      snap(wr, pre, rdy, dwl, er, blk, row);
      eq("R2 pulse: dummy wl on (R10)", dwl, 1);
      eq("R3 block select (R11)", blk, 64'd1 << a[9:4]);
      eq("R3 row select (R11)", {48'd0, row}, 64'd1 << a[3:0]);
      eq("R2 pulse: precharge off", pre, 0);
      if (wr) begin
        eq("R5 drivers on in pulse", wr_drv_en, 1);
        eq("R6 no monitor reset in pulse", wr_mon_rst, 0);
      end
      if (j == n && !to) drive(wr, 1'b0, a ^ 10'h155, 1'b1);
    end
    @(negedge clk);
    drive(wr, 1'b1, a ^ 10'h0F0, 1'b0);
    snap(wr, pre, rdy, dwl, er, blk, row);
    eq("R4 close: dummy wl off", dwl, 0);
    eq("R4 close: select off", blk, 0);
    eq("R4 close: precharge still off", pre, 0);
    eq("R8 close: ready low", rdy, 0);
    eq("R7 error flag", er, to);
    if (wr) begin
      eq("R6 monitor reset in close", wr_mon_rst, 1);
      eq("R5 drivers off in close", wr_drv_en, 0);
    end
    @(negedge clk);
    drive(wr, 1'b0, a, 1'b0);
    snap(wr, pre, rdy, dwl, er, blk, row);
    eq("R4 precharge restored", pre, 1);
    eq("R4 ready restored", rdy, 1);
    eq("R7 error held", er, to);
    if (wr) eq("R6 monitor reset one cycle", wr_mon_rst, 0);
    @(negedge clk);
    snap(wr, pre, rdy, dwl, er, blk, row);
    eq("R8 busy request ignored", pre, 1);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    eq("R1 rd precharge", rd_pre_en, 1);
    eq("R1 wr precharge", wr_pre_en, 1);
    eq("R1 ready", {rd_ready, wr_ready}, 2'b11);
    eq("R1 word lines", {rd_dummy_wl, wr_dummy_wl, |rd_blk_sel, |wr_row_sel}, 0);
    eq("R1 write side", {wr_drv_en, wr_dbl_low, wr_mon_rst}, 0);
    eq("R1 errors", {rd_err, wr_err}, 0);

    tmo_limit = 8'd8;
    for (int a = 0; a < 1024; a++) begin
      run_cyc(1'b0, 10'(a), 1 + (a % 4));
      run_cyc(1'b1, 10'(a), 1 + (a % 3));
    end

    for (int l = 0; l <= 5; l++) begin
      tmo_limit = 8'(l);
      run_cyc(1'b0, 10'(37 + l), 0);
      run_cyc(1'b1, 10'(600 + l), 0);
      run_cyc(1'b0, 10'(900 + l), (l == 0) ? 1 : l);
      run_cyc(1'b1, 10'(17 + l), (l == 0) ? 1 : l);
    end

    tmo_limit = 8'd6;
    for (int k = 0; k < 4; k++) begin
      fork
        run_cyc(1'b0, 10'(100 + 211 * k), 1 + k);
        run_cyc(1'b1, 10'(1000 - 97 * k), 5 - k);
      join
    end
    fork
      run_cyc(1'b0, 10'd513, 0);
      run_cyc(1'b1, 10'd258, 2);
    join
    eq("R9 read error only", {rd_err, wr_err}, 2'b10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule